// File: doc/BRIEF.md
# Serial Flash One-Time-Programmable Region Command Gate

This block sits behind the SPI pins of a serial flash model and decides where array traffic goes and whether it may proceed. It keeps a persistent mode bit. The bit selects either the main array or a separate 4K-bit one-time-programmable (OTP) region. It also keeps a small security register with two bits. One is a factory-lock flag that comes from a strap input. The other is a customer lock-down bit, which can be set once and never cleared.

The SPI pins (mode 0) are oversampled on the system clock. When CS# rises on a byte boundary, the first byte of the frame is taken as the command. A one-clock grant or refusal pulse then goes to the array back end, together with the opcode. The back end uses the region-select output to route a granted read or program. The security register can be read back on SO at any time.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: SI is sampled on rising SCLK, MSB first, and the first 8 bits of a frame form the opcode. A frame is acted on only when CS# rises after a whole, nonzero number of bytes. A frame that ends mid-byte changes no state and produces no pulse.
- R2: A frame made of exactly the single byte 0xB1 sets `otp_sel` to 1 (OTP mode). Exactly 0xC1 clears it to 0. Either opcode followed by further bytes has no effect. Neither opcode produces a pulse.
- R3: After opcode 0x2B, each falling SCLK edge drives the next security-register bit on `so`, starting at the fall after the 8th rising edge, MSB first. The byte is {6'b0, lock-down at bit 1, factory-lock at bit 0}, and it repeats for as long as clocking continues. The command is never refused, even while `busy` is high.
- R4: `so_oe` is high exactly while `cs_n` is low.
- R5: The outcome of a frame appears on the third clock after CS# rises: a `permit` or `reject` pulse one clock long, never both. `cmd_op` carries the opcode while the pulse is high.
- R6: Reads (0x03, 0x0B) are permitted in either mode.
- R7: The configuration and erase group is permitted in main mode and rejected in OTP mode. The group is 0x01, 0x68, 0x36, 0x39, 0x7E, 0x98, 0x60, 0xC7, 0xD8, 0x20 and 0x52.
- R8: Program (0x02) is permitted in main mode. In OTP mode it is permitted while the lock-down bit is 0 and rejected once it is 1.
- R9: A frame of exactly the single byte 0x2F, in main mode with lock-down at 0, is permitted and sets lock-down to 1. In OTP mode, or with lock-down already 1, it is rejected and lock-down is unchanged. Only reset can change lock-down otherwise.
- R10: While `busy` is high, any recognised opcode other than 0x2B on a byte-aligned frame is rejected, and the mode and lock-down bit are unchanged.
- R11: An unrecognised opcode produces no pulse and changes no state.
- R12: Reset puts the block in main mode and loads lock-down from `ldso_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldso_init | input | 1 | Non-volatile lock-down value loaded at reset |
| fact_lock | input | 1 | Factory-lock strap, read back as register bit 0 |
| busy | input | 1 | Back end is programming, erasing or writing a register |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock, idles low |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for `so` |
| otp_sel | output | 1 | 1 routes array access to the OTP region |
| cmd_op | output | 8 | Opcode of the last frame |
| permit | output | 1 | One-clock grant to the array back end |
| reject | output | 1 | One-clock refusal pulse |

## Verification
The bench targets the frame-closing rules. It sends frames of 7, 9 and 20 bits, which a design that counted bits loosely would act on. It also sends the mode opcodes with a trailing byte, which a design that did not insist on a single-byte frame would accept as a mode switch. The lock-down bit is set, set again and then used against a program in OTP mode. A bit that could be rewritten would show as a missing refusal or a wrong register read-back. Busy-time frames check that 0x2B still streams the right repeating byte while everything else is refused with the mode left alone.

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ldso_init,
  input  logic            fact_lock,
  input  logic            busy,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            si,
  output logic            so,
  output logic            so_oe,
  output logic            otp_sel,
  output logic [OP_W-1:0] cmd_op,
  output logic            permit,
  output logic            reject
);
  localparam int BW = $clog2(OP_W);
  localparam logic [OP_W-1:0] OP_ENTER = 8'hB1;
  localparam logic [OP_W-1:0] OP_EXIT  = 8'hC1;
  localparam logic [OP_W-1:0] OP_RDSEC = 8'h2B;
  localparam logic [OP_W-1:0] OP_WRSEC = 8'h2F;
  localparam logic [OP_W-1:0] OP_PROG  = 8'h02;

  logic [2:0]      cs_p, ck_p, si_p;
  logic [BW-1:0]   bitc, oidx;
  logic [1:0]      nbytes;
  logic            op_ok, so_q, mode_q, lock_q;
  logic [OP_W-1:0] sr, op;
  logic [OP_W-1:0] secreg;

  wire cs_fall = ~cs_p[1] & cs_p[2];
  wire cs_rise = cs_p[1] & ~cs_p[2];
  wire ck_rise = ~cs_p[1] & ck_p[1] & ~ck_p[2];
  wire ck_fall = ~cs_p[1] & ~ck_p[1] & ck_p[2];
  wire [OP_W-1:0] sr_next = {sr[OP_W-2:0], si_p[1]};
  wire frame_end = cs_rise & op_ok & (bitc == '0);
  wire one_byte  = (nbytes == 2'd1);

  assign secreg  = {{(OP_W-2){1'b0}}, lock_q, fact_lock};
  assign so      = so_q;
  assign so_oe   = ~cs_n;
  assign otp_sel = mode_q;
  assign cmd_op  = op;

  logic is_rd, is_cfg, known, acc, rej, nmode, nlock;

  always_comb begin
    is_rd  = (op == 8'h03) || (op == 8'h0B);
    is_cfg = op inside {8'h01, 8'h68, 8'h36, 8'h39, 8'h7E, 8'h98,
                        8'h60, 8'hC7, 8'hD8, 8'h20, 8'h52};
    known  = is_rd || is_cfg || (op == OP_PROG) || (op == OP_ENTER) ||
             (op == OP_EXIT) || (op == OP_WRSEC);
    acc    = 1'b0;
    rej    = 1'b0;
    nmode  = mode_q;
    nlock  = lock_q;
    if (frame_end && op != OP_RDSEC) begin
      if (busy) rej = known;
      else if (op == OP_ENTER) begin
        if (one_byte) nmode = 1'b1;
      end else if (op == OP_EXIT) begin
        if (one_byte) nmode = 1'b0;
      end else if (op == OP_WRSEC) begin
        if (one_byte) begin
          if (mode_q || lock_q) rej = 1'b1;
          else begin
            acc   = 1'b1;
            nlock = 1'b1;
          end
        end
      end else if (is_cfg) begin
        acc = ~mode_q;
        rej = mode_q;
      end else if (op == OP_PROG) begin
        rej = mode_q & lock_q;
        acc = ~rej;
      end else if (is_rd) acc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= 3'b111;
      ck_p   <= '0;
      si_p   <= '0;
      bitc   <= '0;
      oidx   <= '0;
      nbytes <= '0;
      op_ok  <= 1'b0;
      sr     <= '0;
      op     <= '0;
      so_q   <= 1'b0;
      mode_q <= 1'b0;
      lock_q <= ldso_init;
      permit <= 1'b0;
      reject <= 1'b0;
    end else begin
      cs_p   <= {cs_p[1:0], cs_n};
      ck_p   <= {ck_p[1:0], sclk};
      si_p   <= {si_p[1:0], si};
      permit <= acc;
      reject <= rej;
      mode_q <= nmode;
      lock_q <= nlock;
      if (cs_fall) begin
        bitc   <= '0;
        oidx   <= '0;
        nbytes <= '0;
        op_ok  <= 1'b0;
        so_q   <= 1'b0;
      end else begin
        if (ck_rise) begin
          sr   <= sr_next;
          bitc <= bitc + 1'b1;
          if (bitc == BW'(OP_W-1)) begin
            if (nbytes != 2'd3) nbytes <= nbytes + 1'b1;
            if (nbytes == 2'd0) begin
              op    <= sr_next;
              op_ok <= 1'b1;
            end
          end
        end
        if (ck_fall && op_ok && op == OP_RDSEC) begin
          so_q <= secreg[~oidx];
          oidx <= oidx + 1'b1;
        end
      end
    end
  end
endmodule

module otp_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic otp_sel,
  input logic permit,
  input logic reject,
  input logic lock_q
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && reject)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (permit || reject) |=> !(permit || reject)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R9
  AST_LOCK_SET_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> (permit && !otp_sel)); // R9
  AST_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(otp_sel) |-> (!permit && !reject)); // R2
  AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(otp_sel) |-> !$past(busy)); // R10
endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .otp_sel(otp_sel),
  .permit(permit), .reject(reject), .lock_q(lock_q)
);

// File: tb/otp_cmd_ctrl_tb.sv
module otp_cmd_ctrl_tb;
  logic clk = 0, rst_n = 0, ldso_init = 0, fact_lock = 1, busy = 0;
  logic cs_n = 1, sclk = 0, si = 0;
  logic so, so_oe, otp_sel, permit, reject;
  logic [7:0] cmd_op;

  otp_cmd_ctrl u_dut (.clk, .rst_n, .ldso_init, .fact_lock, .busy, .cs_n,
    .sclk, .si, .so, .so_oe, .otp_sel, .cmd_op, .permit, .reject);

  always #10 clk = ~clk;

  int cyc = 0, total = 0, fails = 0, exp_cycle = -1, pend_res = 0;
  bit done = 0, m_mode = 0, m_lock = 0, pend_mode = 0, pend_lock = 0;
  logic [7:0] pend_op;
  logic [39:0] rx;
  string pend_tag = "R12";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit ep, er;
    ep = 0; er = 0;
    if (cyc == exp_cycle) begin
      ep = (pend_res == 1); er = (pend_res == 2);
      m_mode = pend_mode; m_lock = pend_lock;
      if (ep || er) chk(cmd_op === pend_op, "R5", {8'h0, cmd_op}, {8'h0, pend_op});
    end
    chk(permit === ep, pend_tag, {15'h0, permit}, {15'h0, ep});
    chk(reject === er, pend_tag, {15'h0, reject}, {15'h0, er});
    chk(otp_sel === m_mode, (cyc == exp_cycle) ? pend_tag : "R2", {15'h0, otp_sel}, {15'h0, m_mode});
    chk(so_oe === !cs_n, "R4", {15'h0, so_oe}, {15'h0, !cs_n});
  end

  task automatic schedule(input logic [7:0] op, input int nb, input string tag);
    bit aligned, exact, known, rd, cfg;
    aligned = (nb >= 8) && (nb % 8 == 0);
    exact = (nb == 8);
    rd = (op == 8'h03) || (op == 8'h0B);
    cfg = (op == 8'h01) || (op == 8'h68) || (op == 8'h36) || (op == 8'h39) ||
          (op == 8'h7E) || (op == 8'h98) || (op == 8'h60) || (op == 8'hC7) ||
          (op == 8'hD8) || (op == 8'h20) || (op == 8'h52);
    known = rd || cfg || op == 8'h02 || op == 8'hB1 || op == 8'hC1 || op == 8'h2F;
    pend_res = 0; pend_mode = m_mode; pend_lock = m_lock; pend_op = op; pend_tag = tag;
    if (aligned && op != 8'h2B) begin
      if (busy) pend_res = known ? 2 : 0;
      else if (op == 8'hB1) begin if (exact) pend_mode = 1; end
      else if (op == 8'hC1) begin if (exact) pend_mode = 0; end
      else if (op == 8'h2F) begin
        if (exact) begin
          if (m_mode || m_lock) pend_res = 2;
          else begin pend_res = 1; pend_lock = 1; end
        end
      end
      else if (cfg) pend_res = m_mode ? 2 : 1;
      else if (op == 8'h02) pend_res = (m_mode && m_lock) ? 2 : 1;
      else if (rd) pend_res = 1;
    end
    exp_cycle = cyc + 3;
  endtask

  task automatic frame(input int nbits, input logic [39:0] d, input string tag);
    rx = '0;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = d[39-i];
      repeat (4) @(negedge clk);
      rx = {rx[38:0], so};
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    schedule(d[39:32], nbits, tag);
    repeat (10) @(negedge clk);
  endtask

  task automatic rdsec(input logic [7:0] exp, input string tag);
    frame(24, {8'h2B, 32'h0}, tag);
    chk(rx[15:0] === {exp, exp}, tag, rx[15:0], {exp, exp});
  endtask

  task automatic do_reset(input bit init);
    @(negedge clk) rst_n = 0; ldso_init = init;
    m_mode = 0; m_lock = init; exp_cycle = -1; pend_tag = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset(0);
    rdsec(8'h01, "R3");
    frame(32, {8'h03, 32'h0}, "R6");
    frame(32, {8'h20, 32'h0}, "R7");
    frame(8, {8'hB1, 32'h0}, "R2");
    frame(32, {8'h20, 32'h0}, "R7");
    frame(8, {8'hC7, 32'h0}, "R7");
    frame(16, {8'h01, 32'h0}, "R7");
    frame(8, {8'h2F, 32'h0}, "R9");
    frame(40, {8'h0B, 32'h0}, "R6");
    frame(40, {8'h02, 32'h12345678}, "R8");
    frame(9, {8'hC1, 32'h0}, "R1");
    frame(7, {8'hC1, 32'h0}, "R1");
    frame(16, {8'hC1, 32'h0}, "R2");
    rdsec(8'h01, "R3");
    frame(8, {8'hC1, 32'h0}, "R2");
    frame(8, {8'hFF, 32'h0}, "R11");
    frame(16, {8'h90, 32'h0}, "R11");
    frame(8, {8'h2F, 32'h0}, "R9");
    rdsec(8'h03, "R9");
    frame(8, {8'h2F, 32'h0}, "R9");
    frame(8, {8'hB1, 32'h0}, "R2");
    frame(40, {8'h02, 32'h0}, "R8");
    frame(32, {8'h03, 32'h0}, "R6");
    frame(8, {8'hC1, 32'h0}, "R2");
    busy = 1;
    rdsec(8'h03, "R3");
    frame(32, {8'h20, 32'h0}, "R10");
    frame(8, {8'hB1, 32'h0}, "R10");
    frame(8, {8'hFF, 32'h0}, "R11");
    frame(32, {8'h03, 32'h0}, "R10");
    busy = 0;
    frame(20, {8'h03, 32'h0}, "R1");
    frame(8, {8'hB1, 32'h0}, "R2");
    do_reset(0);
    chk(otp_sel === 1'b0, "R12", {15'h0, otp_sel}, 16'h0);
    rdsec(8'h01, "R12");
    do_reset(1);
    rdsec(8'h03, "R12");
    frame(8, {8'h2F, 32'h0}, "R9");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule